// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Engine

This block is a single transmit channel. It follows a chain of descriptors held in memory and turns each described buffer into a stream of 32-bit beats. Software loads the first descriptor address into the current-pointer register, sets the run bit, and then writes the address of the last descriptor it has prepared into the tail register. That tail write is what starts the walk. The engine keeps fetching and sending buffers until it has finished the descriptor at the tail address, and then it goes idle. Software starts another batch by moving the tail forward.

A descriptor that begins a packet carries five application words. These go out on a side stream before any of that descriptor's buffer data. The data stream marks the final beat of a packet, and a byte-enable mask shows the valid bytes of a buffer's closing word. After each buffer has been sent, the engine writes a completion word back into the descriptor and pulses a completion output. If the engine fetches a descriptor that has already been completed, it halts.

Top module: `sg_mm2s_engine`

## Requirements
- R1: Register byte offsets are control 0x00, status 0x04, current pointer 0x08 and tail pointer 0x10. A read returns its data on `reg_rdata` in the cycle after `reg_rd`. After reset, control reads 0x0000_0002 and status reads 0x0000_0001. Status bit 0 is halted and status bit 1 is idle.
- R2: Control bit 1 always reads as 1, whatever value was written to it.
- R3: A control write with bit 0 (run) set and bit 2 clear clears both halted and idle, provided no reset is pending.
- R4: A tail write clears idle. The walk starts only if run is 1 and halted is 0. Otherwise the memory port stays untouched and the current pointer does not change.
- R5: Descriptor word layout relative to its address: next pointer at +0x00, buffer address at +0x08, control at +0x18 and status at +0x1C. In the control word, bits 22:0 hold the byte length, bit 26 marks end of packet and bit 27 marks start of packet. Buffer byte 0 is carried on data bits 7:0.
- R6: If the fetched status word has bit 31 set, the engine sets halted and stops. It sends nothing, writes nothing back and leaves the current pointer unchanged.
- R7: For a start-of-packet descriptor, the five words at +0x20..+0x30 go out on the application stream first. `app_last` is set on the fifth word. The two streams are never valid in the same cycle.
- R8: A buffer of length L is sent as ceil(L/4) words read from consecutive buffer addresses. The final word of a buffer carries `m_keep` = 0x1, 0x3 or 0x7 when L mod 4 is 1, 2 or 3; every other word carries 0xF. A length of 0 sends no beats. `m_last` is set only on the final word of an end-of-packet descriptor.
- R9: After a buffer has been sent, the engine writes L OR 0x8000_0000 to +0x1C. `desc_done` pulses in the same cycle as that write.
- R10: After the write-back, the current pointer takes the next-pointer value. If the old pointer equalled the tail, idle is set and the walk ends.
- R11: If run is 0 when a write-back completes, and that descriptor was not the tail, the engine sets halted and stops.
- R12: A control write with bit 2 set aborts any walk, clears run and sets halted. Bit 2 then reads 1 until the next register access, which clears it. A read used as that clearing access still returns 1.
- R13: While `m_valid` is high and `m_ready` is low, the data, keep and last outputs hold steady and no memory read is issued. The same holding rule applies to the application stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_rvalid | input | 1 | Read data valid |
| m_valid | output | 1 | Data stream valid |
| m_ready | input | 1 | Data stream ready |
| m_data | output | 32 | Data stream word |
| m_keep | output | 4 | Valid byte mask |
| m_last | output | 1 | Final beat of a packet |
| app_valid | output | 1 | Application word valid |
| app_ready | input | 1 | Application word ready |
| app_data | output | 32 | Application word |
| app_last | output | 1 | Fifth application word |
| desc_done | output | 1 | One pulse per descriptor write-back |

## Verification
The walk is exercised with four patterns:
- A three-descriptor packet under constant ready. It checks application-word ordering, partial keep masks and the last flag.
- A chain under pseudo-random back-pressure, which mixes a one-descriptor packet, a zero-length descriptor and a word-aligned length. It tells correct stall holding apart from dropped or duplicated beats.
- A descriptor already marked complete, which separates halting from sending.
- A walk where run is cleared while data is held back, which shows the stop taking effect at the descriptor boundary instead of at the tail.

Register-only sequences cover the reset value, the forced mode bit, a tail write while stopped, and the self-clearing reset bit.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int WORD_W    = 32;
  localparam int REG_CTRL  = 'h00;
  localparam int REG_STAT  = 'h04;
  localparam int REG_CUR   = 'h08;
  localparam int REG_TAIL  = 'h10;
  localparam int OFS_STS   = 'h1C;
  localparam int OFS_APP   = 'h20;
  localparam int APP_WORDS = 5;
  localparam int BIT_EOP   = 26;
  localparam int BIT_SOP   = 27;
  localparam int BIT_DONE  = 31;

  typedef enum logic [2:0] {W_IDLE, W_DESC, W_CHK, W_APP, W_DATA, W_WB} walk_st_t;

  // byte offset of the n-th descriptor word fetched (next, buffer, control, status)
  function automatic logic [7:0] desc_word_ofs(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h00;
      2'd1:    return 8'h08;
      2'd2:    return 8'h18;
      default: return 8'h1C;
    endcase
  endfunction

  function automatic logic [3:0] tail_keep(input logic [1:0] rem);
    case (rem)
      2'd1:    return 4'h1;
      2'd2:    return 4'h3;
      2'd3:    return 4'h7;
      default: return 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/sg_regs.sv
module sg_regs
  import sg_pkg::*;
#(
  parameter int AW     = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_cur_upd,
  input  logic [AW-1:0]     eng_cur_val,
  input  logic              eng_set_idle,
  input  logic              eng_set_halt,
  output logic              run,
  output logic              soft_rst,
  output logic              launch,
  output logic [AW-1:0]     cur_ptr,
  output logic [AW-1:0]     tail_ptr
);
  logic halted, idle, rst_pend;
  logic wr_ctrl, wr_cur, wr_tail;

  assign wr_ctrl  = reg_wr && (reg_addr == REG_AW'(REG_CTRL));
  assign wr_cur   = reg_wr && (reg_addr == REG_AW'(REG_CUR));
  assign wr_tail  = reg_wr && (reg_addr == REG_AW'(REG_TAIL));
  assign soft_rst = wr_ctrl && reg_wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      halted    <= 1'b1;
      idle      <= 1'b0;
      rst_pend  <= 1'b0;
      launch    <= 1'b0;
      cur_ptr   <= '0;
      tail_ptr  <= '0;
      reg_rdata <= '0;
    end else begin
      launch <= 1'b0;
      if (eng_set_halt) halted <= 1'b1;
      if (eng_set_idle) idle <= 1'b1;
      if (eng_cur_upd) cur_ptr <= eng_cur_val;
      if ((reg_wr || reg_rd) && rst_pend) rst_pend <= 1'b0;
      if (wr_ctrl) begin
        if (reg_wdata[2]) begin
          rst_pend <= 1'b1;
          run      <= 1'b0;
          halted   <= 1'b1;
          idle     <= 1'b0;
        end else begin
          run <= reg_wdata[0];
          if (reg_wdata[0] && !rst_pend) begin
            halted <= 1'b0;
            idle   <= 1'b0;
          end
        end
      end
      if (wr_cur) cur_ptr <= reg_wdata[AW-1:0];
      if (wr_tail) begin
        tail_ptr <= reg_wdata[AW-1:0];
        idle     <= 1'b0;
        launch   <= run && !halted && !rst_pend && !eng_busy;
      end
      if (reg_rd) begin
        case (reg_addr)
          REG_AW'(REG_CTRL): reg_rdata <= {29'd0, rst_pend, 1'b1, run};
          REG_AW'(REG_STAT): reg_rdata <= {30'd0, idle, halted};
          REG_AW'(REG_CUR):  reg_rdata <= 32'(cur_ptr);
          REG_AW'(REG_TAIL): reg_rdata <= 32'(tail_ptr);
          default:           reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sg_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          launch,
  input  logic          run,
  input  logic [AW-1:0] cur_ptr,
  input  logic [AW-1:0] tail_ptr,
  output logic          busy,
  output logic          cur_upd,
  output logic [AW-1:0] cur_val,
  output logic          set_idle,
  output logic          set_halt,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rvalid,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [31:0]   m_data,
  output logic [3:0]    m_keep,
  output logic          m_last,
  output logic          app_valid,
  input  logic          app_ready,
  output logic [31:0]   app_data,
  output logic          app_last,
  output logic          desc_done
);
  localparam int CNT_W = LEN_W - 1;

  walk_st_t         st;
  logic [2:0]       iss_cnt, rsp_cnt;
  logic [AW-1:0]    nxt_q, buf_q;
  logic [LEN_W-1:0] len_q;
  logic             sop_q, eop_q, done_q, rd_wait;
  logic [CNT_W-1:0] beat, n_words;
  logic             final_beat, at_tail;

  assign n_words    = CNT_W'(len_q >> 2) + CNT_W'(|len_q[1:0]);
  assign final_beat = (beat == n_words - CNT_W'(1));
  assign at_tail    = (cur_ptr == tail_ptr);
  assign busy       = (st != W_IDLE);
  assign cur_upd    = (st == W_WB) && !abort;
  assign cur_val    = nxt_q;
  assign set_idle   = (st == W_WB) && !abort && at_tail;
  assign set_halt   = !abort && (((st == W_CHK) && done_q) ||
                                 ((st == W_WB) && !at_tail && !run));

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st        <= W_IDLE;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      m_valid   <= 1'b0;
      app_valid <= 1'b0;
      desc_done <= 1'b0;
      rd_wait   <= 1'b0;
      iss_cnt   <= '0;
      rsp_cnt   <= '0;
      beat      <= '0;
    end else begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      desc_done <= 1'b0;
      case (st)
        W_IDLE: if (launch) begin
          st      <= W_DESC;
          iss_cnt <= '0;
          rsp_cnt <= '0;
        end
        W_DESC: begin
          if (iss_cnt < 3'd4) begin
            mem_rd   <= 1'b1;
            mem_addr <= cur_ptr + AW'(desc_word_ofs(iss_cnt[1:0]));
            iss_cnt  <= iss_cnt + 3'd1;
          end
          if (mem_rvalid) begin
            case (rsp_cnt[1:0])
              2'd0: nxt_q <= mem_rdata[AW-1:0];
              2'd1: buf_q <= mem_rdata[AW-1:0];
              2'd2: begin
                len_q <= mem_rdata[LEN_W-1:0];
                eop_q <= mem_rdata[BIT_EOP];
                sop_q <= mem_rdata[BIT_SOP];
              end
              default: done_q <= mem_rdata[BIT_DONE];
            endcase
            rsp_cnt <= rsp_cnt + 3'd1;
            if (rsp_cnt == 3'd3) st <= W_CHK;
          end
        end
        W_CHK: begin
          beat    <= '0;
          rd_wait <= 1'b0;
          if (done_q)     st <= W_IDLE;
          else if (sop_q) st <= W_APP;
          else            st <= W_DATA;
        end
        W_APP: begin
          if (!app_valid && !rd_wait) begin
            mem_rd   <= 1'b1;
            mem_addr <= cur_ptr + AW'(OFS_APP) + AW'({beat[2:0], 2'b00});
            rd_wait  <= 1'b1;
          end
          if (rd_wait && mem_rvalid) begin
            app_data  <= mem_rdata;
            app_last  <= (beat == CNT_W'(APP_WORDS - 1));
            app_valid <= 1'b1;
            rd_wait   <= 1'b0;
          end
          if (app_valid && app_ready) begin
            app_valid <= 1'b0;
            if (beat == CNT_W'(APP_WORDS - 1)) begin
              beat <= '0;
              st   <= W_DATA;
            end else begin
              beat <= beat + CNT_W'(1);
            end
          end
        end
        W_DATA: begin
          if (beat == n_words) begin
            st <= W_WB;
          end else begin
            if (!m_valid && !rd_wait) begin
              mem_rd   <= 1'b1;
              mem_addr <= buf_q + AW'({beat, 2'b00});
              rd_wait  <= 1'b1;
            end
            if (rd_wait && mem_rvalid) begin
              m_data  <= mem_rdata;
              m_keep  <= final_beat ? tail_keep(len_q[1:0]) : 4'hF;
              m_last  <= final_beat && eop_q;
              m_valid <= 1'b1;
              rd_wait <= 1'b0;
            end
            if (m_valid && m_ready) begin
              m_valid <= 1'b0;
              beat    <= beat + CNT_W'(1);
            end
          end
        end
        W_WB: begin
          mem_wr    <= 1'b1;
          mem_addr  <= cur_ptr + AW'(OFS_STS);
          mem_wdata <= {1'b1, {(31 - LEN_W){1'b0}}, len_q};
          desc_done <= 1'b1;
          iss_cnt   <= '0;
          rsp_cnt   <= '0;
          st        <= (at_tail || !run) ? W_IDLE : W_DESC;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_mm2s_engine.sv
module sg_mm2s_engine
  import sg_pkg::*;
#(
  parameter int AW     = 32,
  parameter int REG_AW = 5,
  parameter int LEN_W  = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rvalid,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [31:0]       m_data,
  output logic [3:0]        m_keep,
  output logic              m_last,
  output logic              app_valid,
  input  logic              app_ready,
  output logic [31:0]       app_data,
  output logic              app_last,
  output logic              desc_done
);
  logic          run, soft_rst, launch, busy, cur_upd, set_idle, set_halt;
  logic [AW-1:0] cur_ptr, tail_ptr, cur_val;

  sg_regs #(.AW(AW), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(busy),
    .eng_cur_upd(cur_upd), .eng_cur_val(cur_val), .eng_set_idle(set_idle),
    .eng_set_halt(set_halt), .run(run), .soft_rst(soft_rst), .launch(launch),
    .cur_ptr(cur_ptr), .tail_ptr(tail_ptr)
  );

  sg_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .abort(soft_rst), .launch(launch), .run(run),
    .cur_ptr(cur_ptr), .tail_ptr(tail_ptr), .busy(busy), .cur_upd(cur_upd),
    .cur_val(cur_val), .set_idle(set_idle), .set_halt(set_halt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep), .m_last(m_last),
    .app_valid(app_valid), .app_ready(app_ready), .app_data(app_data),
    .app_last(app_last), .desc_done(desc_done)
  );
endmodule

// File: rtl/sg_mm2s_sva.sv
module sg_mm2s_sva #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [31:0]       mem_wdata,
  input logic              m_valid,
  input logic              m_ready,
  input logic [31:0]       m_data,
  input logic [3:0]        m_keep,
  input logic              m_last,
  input logic              app_valid,
  input logic              app_ready,
  input logic [31:0]       app_data,
  input logic              app_last,
  input logic              desc_done
);
  AST_MODE_BIT_SET: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == '0 |=> reg_rdata[1]); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready && !(reg_wr && reg_addr == '0 && reg_wdata[2])
    |=> m_valid && $stable(m_data) && $stable(m_keep) && $stable(m_last)); // R13

  AST_APP_HOLD: assert property (@(posedge clk) disable iff (rst)
    app_valid && !app_ready && !(reg_wr && reg_addr == '0 && reg_wdata[2])
    |=> app_valid && $stable(app_data) && $stable(app_last)); // R13

  AST_NO_READ_STALLED: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |-> !mem_rd); // R13

  AST_STREAMS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(m_valid && app_valid)); // R7

  AST_DONE_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    desc_done |-> mem_wr && mem_wdata[31]); // R9

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R5

  AST_SOFT_RESET_ABORT: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == '0 && reg_wdata[2] |=> !m_valid && !app_valid && !mem_rd); // R12
endmodule

bind sg_mm2s_engine sg_mm2s_sva #(.REG_AW(REG_AW)) u_sva (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_keep(m_keep), .m_last(m_last), .app_valid(app_valid), .app_ready(app_ready),
  .app_data(app_data), .app_last(app_last), .desc_done(desc_done)
);

// File: tb/sg_mm2s_engine_tb.sv
module sg_mm2s_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_rd, mem_wr, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        m_valid, m_ready = 1'b1, m_last;
  logic [31:0] m_data;
  logic [3:0]  m_keep;
  logic        app_valid, app_ready = 1'b1, app_last;
  logic [31:0] app_data;
  logic        desc_done;

  logic [31:0] mem [0:511];
  logic [36:0] data_q [$];
  logic [32:0] app_q [$];
  logic [63:0] wb_q [$];
  int checks = 0, errors = 0, done_cnt = 0, mem_acc = 0, bp_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sg_mm2s_engine u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_keep(m_keep), .m_last(m_last), .app_valid(app_valid), .app_ready(app_ready),
    .app_data(app_data), .app_last(app_last), .desc_done(desc_done)
  );

  // memory with one-cycle read response
  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    if (mem_rd) mem_rdata <= mem[mem_addr[10:2]];
    if (mem_wr) mem[mem_addr[10:2]] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference comparison on every clock, ready updated before sampling
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_ready   = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? lfsr[0] : 1'b0;
    app_ready = (bp_mode == 1) ? lfsr[2] : 1'b1;
    if (!rst) begin
      if (mem_rd || mem_wr) mem_acc++;
      if (desc_done) done_cnt++;
      if (m_valid && m_ready) begin
        if (data_q.size() == 0) chk("R8 unexpected beat", {m_last, m_keep, m_data}, 0);
        else chk("R8 data beat", {m_last, m_keep, m_data}, data_q.pop_front());
      end
      if (app_valid && app_ready) begin
        if (app_q.size() == 0) chk("R7 unexpected app word", {app_last, app_data}, 0);
        else chk("R7 app word", {app_last, app_data}, app_q.pop_front());
      end
      if (mem_wr) begin
        if (wb_q.size() == 0) chk("R9 unexpected write", {mem_addr, mem_wdata}, 0);
        else chk("R9 write-back", {mem_addr, mem_wdata}, wb_q.pop_front());
      end
    end
  end

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic put_desc(input int at, input int nxt, input int bufa, input int ctl, input int sts);
    mem[at >> 2] = nxt;
    mem[(at + 'h08) >> 2] = bufa;
    mem[(at + 'h18) >> 2] = ctl;
    mem[(at + 'h1C) >> 2] = sts;
    for (int j = 0; j < 5; j++) mem[(at + 'h20 + 4 * j) >> 2] = 32'hA000_0000 + at + j;
  endtask

  // behavioural walk of the chain: fills expected queues
  task automatic model_walk(input int start, input int tail, input int max_n);
    int p;
    p = start;
    for (int n = 0; n < max_n; n++) begin
      int ctl, len, words, bufa;
      ctl = mem[(p + 'h18) >> 2];
      if (mem[(p + 'h1C) >> 2][31]) break;
      if (ctl[27]) for (int j = 0; j < 5; j++)
        app_q.push_back({j == 4, mem[(p + 'h20 + 4 * j) >> 2]});
      len = ctl & 32'h7F_FFFF;
      words = (len + 3) / 4;
      bufa = mem[(p + 8) >> 2];
      for (int w = 0; w < words; w++) begin
        logic [3:0] k;
        k = (w == words - 1 && len % 4 != 0) ? 4'((1 << (len % 4)) - 1) : 4'hF;
        data_q.push_back({(w == words - 1) && ctl[26], k, mem[(bufa >> 2) + w]});
      end
      wb_q.push_back({32'(p + 'h1C), 32'(len) | 32'h8000_0000});
      if (p == tail) break;
      p = mem[p >> 2];
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 5000; i++) begin
      if (data_q.size() == 0 && app_q.size() == 0 && wb_q.size() == 0) break;
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk("R8 queues drained", data_q.size() + app_q.size() + wb_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int d0;
    for (int i = 0; i < 512; i++) mem[i] = 32'h1000_0000 + i * 32'h0101_0101;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2: reset values
    reg_read(5'h00, rd); chk("R1 R2 control after reset", rd, 32'h2);
    reg_read(5'h04, rd); chk("R1 status after reset", rd, 32'h1);

    // R4: tail write while stopped does nothing
    put_desc('h000, 'h040, 'h400, 32'h0800_000A, 0);
    put_desc('h040, 'h080, 'h440, 32'h0000_0008, 0);
    put_desc('h080, 'h0C0, 'h480, 32'h0400_0005, 0);
    reg_write(5'h08, 32'h000);
    reg_write(5'h10, 32'h080);
    repeat (20) @(negedge clk);
    chk("R4 no memory access while stopped", mem_acc, 0);
    reg_read(5'h08, rd); chk("R4 pointer unchanged", rd, 32'h000);

    // R2 / R3
    reg_write(5'h00, 32'h0);
    reg_read(5'h00, rd); chk("R2 mode bit forced", rd, 32'h2);
    reg_write(5'h00, 32'h1);
    reg_read(5'h04, rd); chk("R3 run clears halted and idle", rd, 32'h0);

    // chain A under full ready: SOP partial keep, middle aligned, EOP partial
    model_walk('h000, 'h080, 8);
    reg_write(5'h10, 32'h080);
    drain();
    chk("R9 three completion pulses", done_cnt, 3);
    reg_read(5'h04, rd); chk("R10 idle after tail", rd, 32'h2);
    reg_read(5'h08, rd); chk("R10 pointer advanced past tail", rd, 32'h0C0);
    chk("R9 status word in memory", mem[('h040 + 'h1C) >> 2], 32'h8000_0008);

    // chain B under back-pressure: single-descriptor packet, zero length, aligned
    bp_mode = 1;
    put_desc('h0C0, 'h100, 'h500, 32'h0C00_000D, 0);
    put_desc('h100, 'h140, 'h520, 32'h0000_0000, 0);
    put_desc('h140, 'h180, 'h540, 32'h0400_0004, 0);
    model_walk('h0C0, 'h140, 8);
    reg_write(5'h10, 32'h140);
    drain();
    bp_mode = 0;
    chk("R8 zero length still completes", done_cnt, 6);
    reg_read(5'h08, rd); chk("R10 pointer after chain B", rd, 32'h180);

    // R6: descriptor already complete
    put_desc('h180, 'h1C0, 'h580, 32'h0400_0004, 32'h8000_0000);
    reg_write(5'h10, 32'h180);
    repeat (40) @(negedge clk);
    chk("R6 no completion", done_cnt, 6);
    reg_read(5'h04, rd); chk("R6 halted", rd, 32'h1);
    reg_read(5'h08, rd); chk("R6 pointer held", rd, 32'h180);
    chk("R6 status word untouched", mem[('h180 + 'h1C) >> 2], 32'h8000_0000);

    // R11: run cleared while the first buffer is held back
    reg_write(5'h00, 32'h1);
    put_desc('h1C0, 'h200, 'h600, 32'h0400_0010, 0);
    put_desc('h200, 'h240, 'h640, 32'h0400_0004, 0);
    reg_write(5'h08, 32'h1C0);
    model_walk('h1C0, 'h200, 1);
    bp_mode = 2;
    reg_write(5'h10, 32'h200);
    d0 = 0;
    while (!m_valid && d0 < 200) begin @(negedge clk); d0++; end
    reg_write(5'h00, 32'h0);
    bp_mode = 0;
    drain();
    chk("R11 one descriptor finished", done_cnt, 7);
    reg_read(5'h04, rd); chk("R11 halted at boundary", rd, 32'h1);
    reg_read(5'h08, rd); chk("R11 pointer at next", rd, 32'h200);

    // R12: self-clearing reset bit
    reg_write(5'h00, 32'h1);
    reg_write(5'h00, 32'h4);
    reg_read(5'h00, rd); chk("R12 reset bit visible once", rd, 32'h6);
    reg_read(5'h00, rd); chk("R12 reset bit cleared", rd, 32'h2);
    reg_read(5'h04, rd); chk("R12 halted after reset", rd, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule